// File: doc/BRIEF.md
# Software-Wait-Triggered Interrupt Generator

This block issues user interrupts toward a host on behalf of user logic. An eight-bit input reports, one bit per interrupt vector, which vectors software is currently blocked on. For each vector the block implements, a private counter advances on every clock in which software waits on that vector and interrupts are enabled. When the count reaches the vector's threshold, the vector becomes pending. The block then raises a single request line together with a three-bit vector number. It keeps that request up until the host side answers with a clear pulse.

Two vectors are built by default. Vector 0 uses a threshold of 10 and vector 1 uses a threshold of 1000. When both are pending, the lower vector is issued first. After a vector has been served, it stays quiet until software stops waiting on it and then waits again. Its next count starts from zero.

Top module: `swait_irq_gen`

## Requirements
- R1: During and right after reset, `irq_req` is 0 and `irq_vector` is 3'd0.
- R2: With `irq_enable` high and `sw_waiting[0]` held high from a fresh start, vector 0 is pending after 10 rising edges that sample the bit high. `irq_req` is then 1 after the 11th such edge, with `irq_vector` = 3'd0. Vector 1 behaves the same way with 1000 in place of 10 and `irq_vector` = 3'd1.
- R3: Once `irq_req` is 1 it stays 1 until a rising edge samples `irq_clr` high. After that edge it is 0 for at least one cycle.
- R4: While `irq_req` is 1, `irq_vector` does not change, and it carries the index of the vector being served.
- R5: A vector's count advances only on edges where its waiting bit and `irq_enable` are both high. While its waiting bit is low, the count is kept, not lost.
- R6: After its clear, a served vector does not request again while its waiting bit stays high. Once that bit has been low for at least one edge and is high again, counting restarts from zero.
- R7: While `irq_enable` is low, counts are frozen and no new request is raised. A request that is already high stays high.
- R8: When vector 0 and vector 1 become pending on the same edge, vector 0 is requested first. Vector 1 is requested on the second edge after the clear of vector 0.
- R9: Waiting bits 2 to 7, and an `irq_clr` pulse with no request up, have no effect on `irq_req` or on the count of any vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_enable | input | 1 | Allows counting and the raising of new requests |
| sw_waiting | input | 8 | One bit per vector: software is blocked on that vector |
| irq_clr | input | 1 | Host acknowledgement that ends the current request |
| irq_req | output | 1 | Interrupt request, held until cleared |
| irq_vector | output | 3 | Number of the vector being requested |

## Verification
The assertions assume that `irq_clr` only has meaning while a request is up, and that the waiting bits may change on any cycle. The stimulus holds to both. It drives stray clears while no request is up, and it flips waiting bits at random, including while a vector is pending or being served. The random phase toggles `irq_enable` often, so that frozen counts and a request held while disabled both occur. Directed sequences line up both vectors so that they reach their thresholds on the same edge.

// File: rtl/swait_irq_pkg.sv
package swait_irq_pkg;

   // Life cycle of one implemented vector.
   typedef enum logic [1:0] {
      VS_COUNT = 2'd0,  // counting while software waits
      VS_PEND  = 2'd1,  // threshold reached, waiting for the line
      VS_SERVE = 2'd2,  // owns the request line
      VS_DONE  = 2'd3   // served, waits for the wait bit to drop
   } vstate_e;

endpackage

// File: rtl/swait_vec_cell.sv
module swait_vec_cell
   import swait_irq_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter logic [CNT_W-1:0] THRESH = CNT_W'(10)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic waiting,
   input  logic grant,
   input  logic release_i,
   output logic pending
);

   localparam logic [CNT_W-1:0] LAST = THRESH - CNT_W'(1);

   vstate_e          state_q;
   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= VS_COUNT;
         count_q <= '0;
      end else begin
         unique case (state_q)
            VS_COUNT: begin
               if (waiting && enable) begin
                  if (count_q == LAST) begin
                     count_q <= THRESH;
                     state_q <= VS_PEND;
                  end else begin
                     count_q <= count_q + CNT_W'(1);
                  end
               end
            end
            VS_PEND: begin
               if (grant) state_q <= VS_SERVE;
            end
            VS_SERVE: begin
               if (release_i) begin
                  state_q <= VS_DONE;
                  count_q <= '0;
               end
            end
            VS_DONE: begin
               if (!waiting) state_q <= VS_COUNT;
            end
            default: state_q <= VS_COUNT;
         endcase
      end
   end

   assign pending = (state_q == VS_PEND);

endmodule

// File: rtl/swait_arb.sv
module swait_arb #(
   parameter int unsigned NUM_IMPL = 2,
   parameter int unsigned VEC_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                clr,
   input  logic [NUM_IMPL-1:0] pend,
   output logic [NUM_IMPL-1:0] grant,
   output logic [NUM_IMPL-1:0] release_o,
   output logic                req,
   output logic [VEC_W-1:0]    vector
);

   logic             req_q;
   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] pick;
   logic             any_pend;
   logic             take;
   logic             drop;

   // Lowest index wins: scan downward so the last hit is the lowest.
   always_comb begin
      pick     = '0;
      any_pend = 1'b0;
      for (int i = NUM_IMPL - 1; i >= 0; i--) begin
         if (pend[i]) begin
            pick     = VEC_W'(i);
            any_pend = 1'b1;
         end
      end
   end

   assign take = !req_q && enable && any_pend;
   assign drop = req_q && clr;

   always_comb begin
      grant     = '0;
      release_o = '0;
      if (take) grant[pick] = 1'b1;
      if (drop) release_o[vec_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         vec_q <= '0;
      end else if (drop) begin
         req_q <= 1'b0;
      end else if (take) begin
         req_q <= 1'b1;
         vec_q <= pick;
      end
   end

   assign req    = req_q;
   assign vector = vec_q;

endmodule

// File: rtl/swait_irq_gen.sv
module swait_irq_gen #(
   parameter int unsigned VEC_W    = 3,
   parameter int unsigned NUM_IMPL = 2,
   parameter int unsigned CNT_W    = 16,
   parameter logic [NUM_IMPL*CNT_W-1:0] THRESH = {16'd1000, 16'd10}
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                irq_enable,
   input  logic [2**VEC_W-1:0] sw_waiting,
   input  logic                irq_clr,
   output logic                irq_req,
   output logic [VEC_W-1:0]    irq_vector
);

   localparam int unsigned WAIT_W = 2 ** VEC_W;

   if (NUM_IMPL < 1 || NUM_IMPL > WAIT_W) begin : g_bad_count
      $error("NUM_IMPL must lie between 1 and 2**VEC_W");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("CNT_W must lie between 2 and 32");
   end

   logic [NUM_IMPL-1:0] pend;
   logic [NUM_IMPL-1:0] grant;
   logic [NUM_IMPL-1:0] rel;

   for (genvar i = 0; i < NUM_IMPL; i++) begin : g_vec
      if (THRESH[i*CNT_W +: CNT_W] == '0) begin : g_bad_thresh
         $error("a vector threshold of zero is not allowed");
      end
      swait_vec_cell #(
         .CNT_W  (CNT_W),
         .THRESH (THRESH[i*CNT_W +: CNT_W])
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (irq_enable),
         .waiting   (sw_waiting[i]),
         .grant     (grant[i]),
         .release_i (rel[i]),
         .pending   (pend[i])
      );
   end

   if (NUM_IMPL < WAIT_W) begin : g_spare
      logic unused_wait;
      assign unused_wait = ^sw_waiting[WAIT_W-1:NUM_IMPL];
   end

   swait_arb #(
      .NUM_IMPL (NUM_IMPL),
      .VEC_W    (VEC_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (irq_enable),
      .clr       (irq_clr),
      .pend      (pend),
      .grant     (grant),
      .release_o (rel),
      .req       (irq_req),
      .vector    (irq_vector)
   );

endmodule

// File: rtl/swait_irq_chk.sv
module swait_irq_chk #(
   parameter int unsigned VEC_W    = 3,
   parameter int unsigned NUM_IMPL = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_enable,
   input logic             irq_clr,
   input logic             irq_req,
   input logic [VEC_W-1:0] irq_vector
);

   // R3: held until cleared
   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_clr |=> irq_req);

   // R3: clear takes the line down
   a_r3_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_clr |=> !irq_req);

   // R4: vector steady while requested
   a_r4_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_clr |=> $stable(irq_vector));

   // R4: only implemented vectors are ever named
   a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (int'(irq_vector) < NUM_IMPL));

   // R7: no new request while disabled
   a_r7_no_new_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req && !irq_enable |=> !irq_req);

endmodule

bind swait_irq_gen swait_irq_chk #(
   .VEC_W    (VEC_W),
   .NUM_IMPL (NUM_IMPL)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_enable (irq_enable),
   .irq_clr    (irq_clr),
   .irq_req    (irq_req),
   .irq_vector (irq_vector)
);

// File: tb/swait_irq_gen_tb.sv
module swait_irq_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TH0 = 10;
   localparam int TH1 = 1000;
   localparam int MAX_CYC = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq_enable = 1'b0;
   logic [7:0] sw_waiting = '0;
   logic       irq_clr = 1'b0;
   logic       irq_req;
   logic [2:0] irq_vector;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   swait_irq_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_enable (irq_enable),
      .sw_waiting (sw_waiting),
      .irq_clr    (irq_clr),
      .irq_req    (irq_req),
      .irq_vector (irq_vector)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // Reference behaviour from the requirements. The state codes are
   // 0 counting, 1 pending, 2 served, 3 waiting for the bit to drop.
   int m_cnt [2];
   int m_st  [2];
   bit m_req;
   int m_vec;

   function automatic int thresh_of(int v);
      return (v == 0) ? TH0 : TH1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '{0, 0};
         m_st  = '{0, 0};
         m_req = 1'b0;
         m_vec = 0;
      end else begin
         automatic int gnt = -1;
         automatic bit dropped = m_req && irq_clr;
         if (!m_req && irq_enable) begin
            if (m_st[1] == 1) gnt = 1;
            if (m_st[0] == 1) gnt = 0;
         end
         for (int v = 0; v < 2; v++) begin
            case (m_st[v])
               0: if (sw_waiting[v] && irq_enable) begin
                     m_cnt[v]++;
                     if (m_cnt[v] == thresh_of(v)) m_st[v] = 1;
                  end
               1: if (gnt == v) m_st[v] = 2;
               2: if (dropped && m_vec == v) begin
                     m_st[v] = 3;
                     m_cnt[v] = 0;
                  end
               default: if (!sw_waiting[v]) m_st[v] = 0;
            endcase
         end
         if (dropped) m_req = 1'b0;
         else if (gnt >= 0) begin
            m_req = 1'b1;
            m_vec = gnt;
         end
      end
   end

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // Continuous comparison against the reference.
   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         check(irq_req == m_req, "R3 req vs reference", int'(irq_req), int'(m_req));
         check(int'(irq_vector) == m_vec, "R4 vector vs reference", int'(irq_vector), m_vec);
      end
      if (cyc > MAX_CYC && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cyc, MAX_CYC);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_req(bit r, int v, string tag);
      check(irq_req == r, tag, int'(irq_req), int'(r));
      if (r) check(int'(irq_vector) == v, tag, int'(irq_vector), v);
   endtask

   task automatic clr_pulse();
      irq_clr = 1'b1;
      step(1);
      irq_clr = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240917));
      step(3);
      // R1 reset state
      check(irq_req == 1'b0, "R1 req in reset", int'(irq_req), 0);
      check(irq_vector == 3'd0, "R1 vector in reset", int'(irq_vector), 0);
      rst_n = 1'b1;
      step(1);
      check(irq_req == 1'b0, "R1 req after reset", int'(irq_req), 0);

      // R2 vector 0 threshold
      irq_enable = 1'b1;
      sw_waiting = 8'h01;
      step(TH0);
      expect_req(1'b0, 0, "R2 not yet at threshold");
      step(1);
      expect_req(1'b1, 0, "R2 vector 0 request");
      step(5);
      expect_req(1'b1, 0, "R3 held without clear");
      irq_enable = 1'b0;
      step(3);
      expect_req(1'b1, 0, "R7 held while disabled");
      irq_enable = 1'b1;
      clr_pulse();
      expect_req(1'b0, 0, "R3 dropped after clear");

      // R6 no refire while still waiting
      step(40);
      expect_req(1'b0, 0, "R6 quiet while bit stays high");
      sw_waiting = 8'h00;
      step(1);
      sw_waiting = 8'h01;
      step(TH0);
      expect_req(1'b0, 0, "R6 restart counts from zero");
      step(1);
      expect_req(1'b1, 0, "R6 refire after rewait");
      clr_pulse();

      // R7 freeze of counting
      sw_waiting = 8'h00;
      step(1);
      sw_waiting = 8'h01;
      step(5);
      irq_enable = 1'b0;
      step(20);
      expect_req(1'b0, 0, "R7 no request while disabled");
      irq_enable = 1'b1;
      step(TH0 - 5);
      expect_req(1'b0, 0, "R7 count was frozen");
      step(1);
      expect_req(1'b1, 0, "R7 request after re-enable");
      clr_pulse();

      // R5 count kept while not waiting
      sw_waiting = 8'h00;
      step(1);
      sw_waiting = 8'h01;
      step(4);
      sw_waiting = 8'h00;
      step(20);
      expect_req(1'b0, 0, "R5 no count while not waiting");
      sw_waiting = 8'h01;
      step(TH0 - 4);
      expect_req(1'b0, 0, "R5 kept count short of request");
      step(1);
      expect_req(1'b1, 0, "R5 request from kept count");
      clr_pulse();

      // R8 simultaneous threshold
      sw_waiting = 8'h00;
      step(1);
      sw_waiting = 8'h02;
      step(TH1 - TH0);
      sw_waiting = 8'h03;
      step(TH0);
      expect_req(1'b0, 0, "R8 none before threshold");
      step(1);
      expect_req(1'b1, 0, "R8 vector 0 first");
      clr_pulse();
      expect_req(1'b0, 0, "R8 gap after clear");
      step(1);
      expect_req(1'b1, 1, "R8 vector 1 next");
      clr_pulse();

      // R9 spare bits and stray clear
      sw_waiting = 8'h00;
      step(1);
      sw_waiting = 8'hFC;
      step(1500);
      expect_req(1'b0, 0, "R9 spare bits ignored");
      clr_pulse();
      expect_req(1'b0, 0, "R9 stray clear ignored");
      sw_waiting = 8'hFD;
      step(TH0);
      expect_req(1'b0, 0, "R9 count untouched by spares");
      step(1);
      expect_req(1'b1, 0, "R9 vector 0 count intact");
      clr_pulse();

      // Random phase, checked by the reference comparison
      for (int k = 0; k < 30000; k++) begin
         if ($urandom_range(0, 40) == 0)
            sw_waiting[$urandom_range(0, 7)] ^= 1'b1;
         if ($urandom_range(0, 200) == 0)
            sw_waiting[1] = 1'b1;
         irq_enable = ($urandom_range(0, 19) != 0);
         irq_clr = irq_req ? ($urandom_range(0, 7) == 0)
                           : ($urandom_range(0, 29) == 0);
         step(1);
      end
      irq_clr = 1'b0;
      step(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule